// File: doc/BRIEF.md
# PSRAM Configuration Register Write Sequencer

This block programs the two configuration registers of a pseudo-SRAM die. A configuration write differs from an ordinary store. The register value travels on the address lines, and the data lines carry nothing. A dedicated register-enable output stays high across the whole bus cycle. One address bit picks the target register.

A request carries a target select and the refresh-register fields: page mode, temperature range, deep power-down and partial-array refresh. It also carries a raw opcode for the bus control register, and the setup and pulse lengths in clock cycles. The sequencer accepts the request when it is idle and builds the opcode. It then runs one asynchronous write cycle: register-enable lead, chip-select setup, write pulse, hold, and register-enable tail. It reports completion with a one-cycle done pulse.

Top module: `cfgreg_wr_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, the outputs are as follows: `busy` and `done` low, `mem_cre` low, `mem_cs_n` and `mem_we_n` high, `mem_oe_n` high, `mem_dq_oe` low, and `mem_addr` zero.
- R2: Address bit 19 of the opcode selects the target. `req_sel`=0 drives 0 there and targets the refresh register. `req_sel`=1 drives 1 there and targets the bus control register. For the bus control register, every other address bit copies `req_raw`.
- R3: In a refresh-register opcode, address bit 7 equals `req_page_en`: 1 turns page mode on, 0 leaves it off.
- R4: In a refresh-register opcode, address bits 6:5 equal `req_temp`. The codes are 00 = 70 °C, 01 = 45 °C, 10 = 15 °C and 11 = 85 °C.
- R5: In a refresh-register opcode, address bit 4 is the inverse of `req_dpd_en`. A request that enables deep power-down drives 0 there, and one that disables it drives 1.
- R6: In a refresh-register opcode, address bits 2:0 equal `req_par`. The codes are:
  - 000: whole array.
  - 001, 010 and 011: lower 3/4, 1/2 and 1/4.
  - 100: no rows.
  - 101, 110 and 111: upper 3/4, 1/2 and 1/4.
- R7: In a refresh-register opcode, address bit 3 and every bit from 8 upward other than bit 19 are driven 0, whatever `req_raw` holds.
- R8: `mem_cre` rises LEAD_CYC cycles before `mem_cs_n` falls. It stays high until TAIL_CYC cycles after `mem_cs_n` rises. `mem_addr` is stable for the whole time `mem_cre` is high.
- R9: `mem_cs_n` is low for `req_setup`+1 cycles before `mem_we_n` falls. `mem_we_n` stays low for `req_pulse`+1 cycles. `mem_cs_n` stays low for exactly one cycle after `mem_we_n` rises.
- R10: The data bus is never driven (`mem_dq_oe` low) and `mem_oe_n` stays high.
- R11: `busy` rises in the cycle after a request is accepted and stays high through the tail phase. `done` is a single-cycle pulse in the first cycle in which `busy` is low again.
- R12: A request presented while `busy` is high is ignored. It does not change `mem_addr` during the running cycle and it does not start a further cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted only when idle |
| req_sel | input | 1 | Target: 0 = refresh register, 1 = bus control register |
| req_page_en | input | 1 | Page mode enable |
| req_temp | input | 2 | Temperature range code |
| req_dpd_en | input | 1 | Deep power-down enable (active high at this port) |
| req_par | input | 3 | Partial-array refresh code |
| req_raw | input | ADDR_W | Raw opcode for the bus control register |
| req_setup | input | TW | Chip-select-to-write setup length minus one |
| req_pulse | input | TW | Write pulse length minus one |
| busy | output | 1 | A configuration cycle is in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | ADDR_W | Address bus carrying the opcode |
| mem_cre | output | 1 | Configuration-register enable, active high |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, held high |
| mem_dq_oe | output | 1 | Data bus driver enable, held low |

## Verification
The bench builds the block with ADDR_W=24, TW=4, LEAD_CYC=2 and TAIL_CYC=3. The guard phases differ from each other and from one cycle, so a swapped or off-by-one guard count shows in the measured widths. With TW=4 the bench can reach both extremes of the setup and pulse lengths: zero, which gives one cycle each, and 15, which gives sixteen cycles each. A 24-bit bus is wide enough to hold register-select bit 19 and reserved bit 20, as well as the bits above them that a raw bus control opcode fills with ones.

// File: rtl/cfgreg_pkg.sv
package cfgreg_pkg;

    // Opcode bit positions for the refresh register; the device decodes them.
    localparam int PAGE_BIT = 7;
    localparam int TEMP_LSB = 5;
    localparam int TEMP_W   = 2;
    localparam int DPD_BIT  = 4;
    localparam int PAR_LSB  = 0;
    localparam int PAR_W    = 3;

    typedef enum logic [TEMP_W-1:0] {
        TEMP_70C = 2'b00,
        TEMP_45C = 2'b01,
        TEMP_15C = 2'b10,
        TEMP_85C = 2'b11
    } temp_range_e;

    typedef enum logic [PAR_W-1:0] {
        PAR_ALL     = 3'b000,
        PAR_LOW_3Q  = 3'b001,
        PAR_LOW_HALF= 3'b010,
        PAR_LOW_1Q  = 3'b011,
        PAR_NONE    = 3'b100,
        PAR_UP_3Q   = 3'b101,
        PAR_UP_HALF = 3'b110,
        PAR_UP_1Q   = 3'b111
    } par_region_e;

    typedef struct packed {
        logic        page_en;
        temp_range_e temp;
        logic        dpd_en;
        par_region_e par;
    } rfr_fields_t;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_LEAD  = 3'd1,
        PH_SETUP = 3'd2,
        PH_PULSE = 3'd3,
        PH_HOLD  = 3'd4,
        PH_TAIL  = 3'd5
    } phase_e;

    typedef struct packed {
        logic cre;
        logic cs_n;
        logic we_n;
    } bus_ctl_t;

    // Control line levels for each phase of the configuration cycle.
    function automatic bus_ctl_t phase_controls(phase_e ph);
        bus_ctl_t c;
        c.cre  = (ph != PH_IDLE);
        c.cs_n = !(ph == PH_SETUP || ph == PH_PULSE || ph == PH_HOLD);
        c.we_n = (ph != PH_PULSE);
        return c;
    endfunction

endpackage

// File: rtl/cfgreg_opcode_build.sv
module cfgreg_opcode_build
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int CTRL_SEL_BIT = 19
) (
    input  logic              sel,
    input  rfr_fields_t       fields,
    input  logic [ADDR_W-1:0] raw,
    output logic [ADDR_W-1:0] opcode
);

    logic [ADDR_W-1:0] rfr_op;

    // Refresh register opcode: every bit not named below is reserved and stays 0.
    always_comb begin
        rfr_op = '0;
        rfr_op[PAGE_BIT]                  = fields.page_en;
        rfr_op[TEMP_LSB +: TEMP_W]        = fields.temp;
        rfr_op[DPD_BIT]                   = ~fields.dpd_en;
        rfr_op[PAR_LSB +: PAR_W]          = fields.par;
    end

    always_comb begin
        if (sel) begin
            opcode               = raw;
            opcode[CTRL_SEL_BIT] = 1'b1;
        end else begin
            opcode               = rfr_op;
            opcode[CTRL_SEL_BIT] = 1'b0;
        end
    end

endmodule

// File: rtl/cfgreg_phase_timer.sv
module cfgreg_phase_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expired = (cnt == '0);

endmodule

// File: rtl/cfgreg_wr_fsm.sv
module cfgreg_wr_fsm
    import cfgreg_pkg::*;
#(
    parameter int TW       = 4,
    parameter int LEAD_CYC = 1,
    parameter int TAIL_CYC = 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [TW-1:0] setup_len,
    input  logic [TW-1:0] pulse_len,
    input  logic          expired,
    output logic          load,
    output logic [TW-1:0] load_val,
    output phase_e        phase,
    output logic          done
);

    // Guard lengths are loaded as count-minus-one; both must be 1..2**TW.
    localparam logic [TW-1:0] LEAD_LOAD = TW'(LEAD_CYC - 1);
    localparam logic [TW-1:0] TAIL_LOAD = TW'(TAIL_CYC - 1);

    phase_e nxt;
    logic   finish;

    always_comb begin
        nxt      = phase;
        load     = 1'b0;
        load_val = '0;
        finish   = 1'b0;
        case (phase)
            PH_IDLE: if (start) begin
                nxt = PH_LEAD;  load = 1'b1; load_val = LEAD_LOAD;
            end
            PH_LEAD: if (expired) begin
                nxt = PH_SETUP; load = 1'b1; load_val = setup_len;
            end
            PH_SETUP: if (expired) begin
                nxt = PH_PULSE; load = 1'b1; load_val = pulse_len;
            end
            PH_PULSE: if (expired) begin
                nxt = PH_HOLD;  load = 1'b1; load_val = '0;
            end
            PH_HOLD: if (expired) begin
                nxt = PH_TAIL;  load = 1'b1; load_val = TAIL_LOAD;
            end
            PH_TAIL: if (expired) begin
                nxt = PH_IDLE;  finish = 1'b1;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            done  <= 1'b0;
        end else begin
            phase <= nxt;
            done  <= finish;
        end
    end

endmodule

// File: rtl/cfgreg_wr_seq.sv
module cfgreg_wr_seq
    import cfgreg_pkg::*;
#(
    parameter int ADDR_W       = 24,
    parameter int CTRL_SEL_BIT = 19,
    parameter int TW           = 4,
    parameter int LEAD_CYC     = 1,
    parameter int TAIL_CYC     = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_sel,
    input  logic              req_page_en,
    input  logic [1:0]        req_temp,
    input  logic              req_dpd_en,
    input  logic [2:0]        req_par,
    input  logic [ADDR_W-1:0] req_raw,
    input  logic [TW-1:0]     req_setup,
    input  logic [TW-1:0]     req_pulse,
    output logic              busy,
    output logic              done,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_cre,
    output logic              mem_cs_n,
    output logic              mem_we_n,
    output logic              mem_oe_n,
    output logic              mem_dq_oe
);

    typedef struct packed {
        logic [ADDR_W-1:0] op;
        logic [TW-1:0]     setup;
        logic [TW-1:0]     pulse;
    } txn_t;

    rfr_fields_t       fields;
    logic [ADDR_W-1:0] opcode;
    txn_t              txn_q;
    phase_e            phase;
    logic              start;
    logic              tmr_load;
    logic [TW-1:0]     tmr_val;
    logic              tmr_expired;
    bus_ctl_t          ctl;

    always_comb begin
        fields.page_en = req_page_en;
        fields.temp    = temp_range_e'(req_temp);
        fields.dpd_en  = req_dpd_en;
        fields.par     = par_region_e'(req_par);
    end

    cfgreg_opcode_build #(
        .ADDR_W       (ADDR_W),
        .CTRL_SEL_BIT (CTRL_SEL_BIT)
    ) i_opcode (
        .sel    (req_sel),
        .fields (fields),
        .raw    (req_raw),
        .opcode (opcode)
    );

    assign start = req_valid && (phase == PH_IDLE);

    // The whole transaction is frozen at acceptance; later requests never reach it.
    always_ff @(posedge clk) begin
        if (rst) begin
            txn_q <= '0;
        end else if (start) begin
            txn_q.op    <= opcode;
            txn_q.setup <= req_setup;
            txn_q.pulse <= req_pulse;
        end
    end

    cfgreg_phase_timer #(
        .TW (TW)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    cfgreg_wr_fsm #(
        .TW       (TW),
        .LEAD_CYC (LEAD_CYC),
        .TAIL_CYC (TAIL_CYC)
    ) i_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .setup_len (txn_q.setup),
        .pulse_len (txn_q.pulse),
        .expired   (tmr_expired),
        .load      (tmr_load),
        .load_val  (tmr_val),
        .phase     (phase),
        .done      (done)
    );

    assign ctl       = phase_controls(phase);
    assign busy      = (phase != PH_IDLE);
    assign mem_cre   = ctl.cre;
    assign mem_cs_n  = ctl.cs_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_addr  = busy ? txn_q.op : '0;
    assign mem_oe_n  = 1'b1;
    assign mem_dq_oe = 1'b0;

endmodule

// File: rtl/cfgreg_wr_seq_chk.sv
module cfgreg_wr_seq_chk #(
    parameter int ADDR_W = 24
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_cre,
    input logic              mem_cs_n,
    input logic              mem_we_n,
    input logic              mem_oe_n,
    input logic              mem_dq_oe
);

    assert_we_inside_cs_R9: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> !mem_cs_n);

    assert_cs_inside_cre_R8: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> mem_cre);

    assert_cre_leads_cs_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_cs_n) |-> $past(mem_cre));

    assert_cre_trails_cs_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cs_n) |-> mem_cre);

    assert_cs_holds_after_we_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> !mem_cs_n);

    assert_addr_stable_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_cre && $past(mem_cre)) |-> $stable(mem_addr));

    assert_data_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !mem_dq_oe && mem_oe_n);

    assert_accept_R11: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy);

    assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_at_end_R11: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    assert_busy_ignores_req_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_addr));

endmodule

bind cfgreg_wr_seq cfgreg_wr_seq_chk #(
    .ADDR_W (ADDR_W)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .busy      (busy),
    .done      (done),
    .mem_addr  (mem_addr),
    .mem_cre   (mem_cre),
    .mem_cs_n  (mem_cs_n),
    .mem_we_n  (mem_we_n),
    .mem_oe_n  (mem_oe_n),
    .mem_dq_oe (mem_dq_oe)
);

// File: tb/test_cfgreg_wr_seq.sv
module test_cfgreg_wr_seq;

    localparam int ADDR_W   = 24;
    localparam int SEL_BIT  = 19;
    localparam int TW       = 4;
    localparam int LEAD_CYC = 2;
    localparam int TAIL_CYC = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_sel = 1'b0;
    logic              req_page_en = 1'b0;
    logic [1:0]        req_temp = '0;
    logic              req_dpd_en = 1'b0;
    logic [2:0]        req_par = '0;
    logic [ADDR_W-1:0] req_raw = '0;
    logic [TW-1:0]     req_setup = '0;
    logic [TW-1:0]     req_pulse = '0;
    logic              busy, done, mem_cre, mem_cs_n, mem_we_n, mem_oe_n, mem_dq_oe;
    logic [ADDR_W-1:0] mem_addr;

    int checks   = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    cfgreg_wr_seq #(
        .ADDR_W       (ADDR_W),
        .CTRL_SEL_BIT (SEL_BIT),
        .TW           (TW),
        .LEAD_CYC     (LEAD_CYC),
        .TAIL_CYC     (TAIL_CYC)
    ) i_cfgreg_wr_seq (
        .clk (clk), .rst (rst), .req_valid (req_valid), .req_sel (req_sel),
        .req_page_en (req_page_en), .req_temp (req_temp), .req_dpd_en (req_dpd_en),
        .req_par (req_par), .req_raw (req_raw), .req_setup (req_setup),
        .req_pulse (req_pulse), .busy (busy), .done (done), .mem_addr (mem_addr),
        .mem_cre (mem_cre), .mem_cs_n (mem_cs_n), .mem_we_n (mem_we_n),
        .mem_oe_n (mem_oe_n), .mem_dq_oe (mem_dq_oe)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    endtask

    // R1: state while reset is held and right after release.
    task automatic test_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            check(busy == 1'b0 && done == 1'b0, "R1 busy/done", {busy, done}, 0);
            check(mem_cre == 1'b0 && mem_cs_n && mem_we_n, "R1 controls",
                  {mem_cre, mem_cs_n, mem_we_n}, 3'b011);
            check(mem_oe_n && !mem_dq_oe, "R1 data side", {mem_oe_n, mem_dq_oe}, 2'b10);
            check(mem_addr == '0, "R1 addr", mem_addr, 0);
            rst = 1'b0;
            @(negedge clk);
        end
    endtask

    // One configuration write, measured phase by phase from the pins.
    task automatic run_txn(input bit sel, input bit page, input logic [1:0] temp,
                           input bit dpd, input logic [2:0] par,
                           input logic [ADDR_W-1:0] raw, input int setup,
                           input int pulse, input bit inject, input string atag);
        logic [ADDR_W-1:0] exp_addr;
        logic [ADDR_W-1:0] first_addr = '0;
        int n_cre = 0, n_busy = 0, n_we = 0, lead = 0, tail = 0, su = 0, hold = 0;
        int unstable = 0, drive_bad = 0, cyc = 0;
        bit seen_cs = 0, seen_we = 0, seen_done = 0, first = 1;
        int exp_total = LEAD_CYC + setup + pulse + 3 + TAIL_CYC;

        if (sel) begin
            exp_addr = raw;
            exp_addr[SEL_BIT] = 1'b1;
        end else begin
            exp_addr = '0;
            exp_addr[7]   = page;
            exp_addr[6:5] = temp;
            exp_addr[4]   = ~dpd;
            exp_addr[2:0] = par;
        end

        @(negedge clk);
        req_sel = sel; req_page_en = page; req_temp = temp; req_dpd_en = dpd;
        req_par = par; req_raw = raw; req_setup = TW'(setup); req_pulse = TW'(pulse);
        req_valid = 1'b1;
        @(negedge clk);
        while (!seen_done && cyc < 300) begin
            if (inject && cyc >= 1 && cyc <= 3) begin
                req_valid = 1'b1; req_sel = ~sel; req_raw = ~raw; req_par = ~par;
                req_page_en = ~page; req_setup = '0; req_pulse = '0;
            end else begin
                req_valid = 1'b0;
            end
            if (mem_cre) begin
                n_cre++;
                if (first) begin first_addr = mem_addr; first = 0; end
                else if (mem_addr != first_addr) unstable++;
                if (mem_cs_n && !seen_cs) lead++;
                if (mem_cs_n && seen_cs) tail++;
            end
            if (busy) n_busy++;
            if (!mem_cs_n) begin
                seen_cs = 1;
                if (!mem_we_n) begin seen_we = 1; n_we++; end
                else if (!seen_we) su++;
                else hold++;
            end
            if (mem_dq_oe || !mem_oe_n) drive_bad++;
            if (done) begin
                seen_done = 1;
                check(!busy && !mem_cre, "R11 idle at done", {busy, mem_cre}, 0);
            end
            cyc++;
            @(negedge clk);
        end
        req_valid = 1'b0;

        check(first_addr == exp_addr, atag, first_addr, exp_addr);
        if (!sel)
            check((first_addr & 24'hFFFF08) == 0, "R7 reserved bits", first_addr & 24'hFFFF08, 0);
        check(first_addr[SEL_BIT] == sel, "R2 select bit", first_addr[SEL_BIT], sel);
        check(unstable == 0, "R8 addr stable", unstable, 0);
        check(lead == LEAD_CYC, "R8 lead", lead, LEAD_CYC);
        check(tail == TAIL_CYC, "R8 tail", tail, TAIL_CYC);
        check(su == setup + 1, "R9 setup", su, setup + 1);
        check(n_we == pulse + 1, "R9 pulse", n_we, pulse + 1);
        check(hold == 1, "R9 hold", hold, 1);
        check(drive_bad == 0, "R10 data bus idle", drive_bad, 0);
        check(n_cre == exp_total, "R8 cre span", n_cre, exp_total);
        check(n_busy == exp_total, "R11 busy span", n_busy, exp_total);
        check(seen_done, "R11 done seen", seen_done, 1);
        check(done == 1'b0, "R11 done one cycle", done, 0);
        for (int k = 0; k < 3; k++) begin
            check(!busy && !mem_cre && mem_addr == '0, "R12 no extra cycle",
                  {busy, mem_cre, mem_addr}, 0);
            @(negedge clk);
        end
    endtask

    task automatic test_refresh_defaults();
        run_txn(1'b0, 1'b0, 2'b00, 1'b0, 3'b000, '0, 1, 2, 1'b0, "R5 default opcode 0x10");
    endtask

    task automatic test_refresh_fields();
        run_txn(1'b0, 1'b1, 2'b11, 1'b1, 3'b101, 24'hFFFFFF, 0, 0, 1'b0, "R3 page/85C/dpd on/upper3q");
        run_txn(1'b0, 1'b0, 2'b01, 1'b0, 3'b011, 24'h0A5A5A, 2, 1, 1'b0, "R4 45C lower1q");
        run_txn(1'b0, 1'b1, 2'b10, 1'b0, 3'b100, 24'h100008, 1, 1, 1'b0, "R6 15C none");
        run_txn(1'b0, 1'b0, 2'b00, 1'b1, 3'b111, 24'h000000, 0, 3, 1'b0, "R6 upper1q dpd on");
    endtask

    task automatic test_bus_ctrl();
        run_txn(1'b1, 1'b0, 2'b00, 1'b0, 3'b000, 24'hFFFFFF, 1, 1, 1'b0, "R2 raw all ones");
        run_txn(1'b1, 1'b1, 2'b11, 1'b1, 3'b111, 24'h000123, 0, 0, 1'b0, "R2 raw small");
    endtask

    task automatic test_timing_extremes();
        run_txn(1'b0, 1'b1, 2'b00, 1'b0, 3'b010, '0, 15, 15, 1'b0, "R9 max widths opcode");
        run_txn(1'b0, 1'b0, 2'b11, 1'b0, 3'b001, '0, 5, 9, 1'b0, "R9 mid widths opcode");
    endtask

    task automatic test_ignore_busy();
        run_txn(1'b0, 1'b1, 2'b01, 1'b1, 3'b110, 24'h00F0F0, 2, 2, 1'b1, "R12 opcode under injection");
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        test_reset();
        test_refresh_defaults();
        test_refresh_fields();
        test_bus_ctrl();
        test_timing_extremes();
        test_ignore_busy();
        finished = 1;
        summary();
        $finish;
    end

endmodule